// File: doc/BRIEF.md
# Reloadable Down-Counter with Watchdog Mode

An 8-bit down-counter that advances on a tick chosen from four divisions of a slow sub-clock strobe. It loads its start value from two 4-bit nibble registers, the high and the low half. A 4-bit control/status register controls it. One bit picks between a plain timer and a watchdog, one bit enables auto-reload, one bit starts and stops the count, and one read-only bit records a watchdog expiry.

Software writes the reload nibbles and the rate code, then sets the start bit. A 0-to-1 change of the start bit loads the counter. Each tick then takes one off the count, and the step from 00h to FFh is an underflow. With auto-reload on, the counter reloads and keeps running. With it off, the start bit clears itself and the count stops at FFh.

In watchdog mode an underflow latches the expiry flag and pulses a system-reset request. The surrounding chip is expected to feed that request back into `rst_n`. That reset clears everything except the expiry flag. Only `por_n` or the `ram_wr_clr` input clear the flag.

Top module: `dtmr_timer`

## Requirements
- R1: While `por_n` is low at a clock edge, every register clears, including the expiry flag. All readable locations then read 0, and `underflow` and `sys_rst_req` are low.
- R2: Register map by address: 0 is the reload low nibble, 1 the reload high nibble, 2 the control/status, 3 the rate code (bits 1:0, upper bits read 0), 4 the count low nibble, 5 the count high nibble, and 6–7 read 0. Writes to addresses 4–7 have no effect.
- R3: Control bit 3 is the start bit. A write to address 2 that sets it while it is 0 loads the count with {high, low} at that edge.
- R4: A write that sets bit 3 while it is already 1 does not reload the count.
- R5: While bit 3 is 1, the count drops by one per tick. With bit 3 at 0, or with `sub_en` held low, the count holds.
- R6: Rate codes 0, 1, 2 and 3 give one tick per 2, 8, 16 and 32 `sub_en` strobes. With `sub_en` held high and auto-reload on, underflows come exactly D×(N+1) clocks apart, where D is the division and N is the reload value.
- R7: A tick at count 00h is an underflow, and `underflow` is high for exactly one clock. Control bit 2 is auto-reload. With bit 2 at 1, the count reloads {high, low} and bit 3 stays 1.
- R8: With bit 2 at 0, an underflow clears bit 3, leaves the count at FFh, and no further underflow follows.
- R9: With control bit 0 at 0 (timer mode), an underflow leaves `sys_rst_req` low and the expiry flag unchanged.
- R10: With bit 0 at 1 (watchdog mode), an underflow sets control bit 1 (the expiry flag) and raises `sys_rst_req` for one clock, in the same clock as `underflow`.
- R11: A low `rst_n` clears the reload, rate, count and control bits 0, 2 and 3, but keeps bit 1.
- R12: Bit 1 ignores writes. It clears only on `por_n` low or `ram_wr_clr` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low, clears everything |
| rst_n | input | 1 | System reset, synchronous, active low, keeps the expiry flag |
| ram_wr_clr | input | 1 | Clears the expiry flag |
| sub_en | input | 1 | One-clock strobe marking a sub-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 4 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 4 | Read data, combinational from `rd_addr` |
| underflow | output | 1 | One-clock pulse per underflow |
| sys_rst_req | output | 1 | One-clock system-reset request on watchdog expiry |

## Verification
A register write, including the start-bit load, is visible on `rd_data` at the falling edge after the rising edge that takes it. `underflow` and `sys_rst_req` rise at the edge that makes the final tick and are sampled at the following falling edge. The `rst_n` reset that the bench derives from `sys_rst_req` takes effect one edge later. The prescaler runs free, so the phase of the first tick is unknown. The checks on rate and reload therefore time the clocks between two consecutive underflows rather than from the start write.

// File: rtl/dtmr_pkg.sv
// Package: shared constants for the reloadable down-counter.
// Assumes a 3-bit register address and a 4-bit control/status register.
package dtmr_pkg;
    localparam int ADR_LO     = 0;
    localparam int ADR_HI     = 1;
    localparam int ADR_CTRL   = 2;
    localparam int ADR_RATE   = 3;
    localparam int ADR_CNT_LO = 4;
    localparam int ADR_CNT_HI = 5;

    // Control/status bit positions (software-visible behaviour)
    localparam int CTL_WDT  = 0;
    localparam int CTL_FLAG = 1;
    localparam int CTL_AUTO = 2;
    localparam int CTL_RUN  = 3;

    // Number of low prescaler bits that must be all ones for a tick
    function automatic int rate_shift(input logic [1:0] code);
        return (code == 2'd0) ? 1 : int'(code) + 2;
    endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
// Prescaler: free-running counter advanced by the sub-clock strobe.
// Emits a one-clock tick every 2/8/16/32 strobes as picked by sel.
// Assumes PRE_W is wide enough for the largest division (5 bits).
module dtmr_prescaler #(
    parameter int PRE_W = 5,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             sub_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    // Build the mask of low bits that must be all ones
    always_comb begin
        mask = PRE_W'((1 << dtmr_pkg::rate_shift(2'(sel))) - 1);
    end

    // Tick on the strobe that completes a full division period
    assign tick = sub_en && ((div_q & mask) == mask);

    // Count sub-clock strobes
    always_ff @(posedge clk) begin
        if (!clr_n)
            div_q <= '0;
        else if (sub_en)
            div_q <= div_q + PRE_W'(1);
    end
endmodule

// File: rtl/dtmr_regs.sv
// Register bank: reload nibbles, rate code, control bits and expiry flag.
// Detects the 0-to-1 start edge on a control write. Hardware stop
// overrides a same-cycle software write of the start bit.
module dtmr_regs #(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 3,
    parameter int SEL_W  = 2,
    localparam int CNT_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              clr_n,
    input  logic              ram_wr_clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              hw_stop,
    input  logic              hw_flag_set,
    output logic [CNT_W-1:0]  reload_val,
    output logic [SEL_W-1:0]  rate_sel,
    output logic              run,
    output logic              auto_rl,
    output logic              wdt_mode,
    output logic              flag,
    output logic              start_load
);
    import dtmr_pkg::*;

    logic [NIB_W-1:0] lo_q, hi_q;
    logic             wr_ctrl;

    assign wr_ctrl    = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign start_load = wr_ctrl && wr_data[CTL_RUN] && !run;
    assign reload_val = {hi_q, lo_q};

    // Reload nibbles and rate code
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            lo_q     <= '0;
            hi_q     <= '0;
            rate_sel <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_LO))   lo_q     <= wr_data;
            if (wr_addr == ADDR_W'(ADR_HI))   hi_q     <= wr_data;
            if (wr_addr == ADDR_W'(ADR_RATE)) rate_sel <= wr_data[SEL_W-1:0];
        end
    end

    // Writable control bits; a hardware stop wins over the write
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            run      <= 1'b0;
            auto_rl  <= 1'b0;
            wdt_mode <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run      <= wr_data[CTL_RUN];
                auto_rl  <= wr_data[CTL_AUTO];
                wdt_mode <= wr_data[CTL_WDT];
            end
            if (hw_stop)
                run <= 1'b0;
        end
    end

    // Expiry flag: only power-on reset or the explicit clear remove it
    always_ff @(posedge clk) begin
        if (!por_n)
            flag <= 1'b0;
        else if (ram_wr_clr)
            flag <= 1'b0;
        else if (hw_flag_set)
            flag <= 1'b1;
    end
endmodule

// File: rtl/dtmr_counter.sv
// Down-counter core: loads on start edge, steps on tick while running,
// detects underflow and registers the underflow and reset-request pulses.
// Assumes load and tick are single-cycle strobes; load has priority.
module dtmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             run,
    input  logic             auto_rl,
    input  logic             wdt_mode,
    output logic [CNT_W-1:0] count,
    output logic             uf_q,
    output logic             req_q,
    output logic             hw_stop,
    output logic             hw_flag_set
);
    logic uf_evt;

    // Underflow when a live tick meets a zero count
    assign uf_evt      = tick && run && !load && (count == '0);
    assign hw_stop     = uf_evt && !auto_rl;
    assign hw_flag_set = uf_evt && wdt_mode;

    // Count register: load, reload on underflow, or decrement
    always_ff @(posedge clk) begin
        if (!clr_n)
            count <= '0;
        else if (load)
            count <= reload_val;
        else if (uf_evt && auto_rl)
            count <= reload_val;
        else if (tick && run)
            count <= count - CNT_W'(1);
    end

    // Registered pulses for underflow and watchdog reset request
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            uf_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            uf_q  <= uf_evt;
            req_q <= uf_evt && wdt_mode;
        end
    end
endmodule

// File: rtl/dtmr_timer.sv
// Top: reloadable 8-bit down-counter with timer and watchdog modes.
// Connects prescaler, register bank and counter core; drives the read mux.
// Assumes synchronous active-low resets; por_n dominates rst_n.
module dtmr_timer #(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 3,
    parameter int SEL_W  = 2,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              ram_wr_clr,
    input  logic              sub_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NIB_W-1:0]  rd_data,
    output logic              underflow,
    output logic              sys_rst_req
);
    import dtmr_pkg::*;
    localparam int CNT_W = 2 * NIB_W;

    logic             clr_n;
    logic             tick_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    logic [SEL_W-1:0] sel_w;
    logic             run_w, auto_w, wdt_w, flag_w;
    logic             load_w, stop_w, fset_w;
    logic [NIB_W-1:0] ctrl_rd;

    assign clr_n = por_n && rst_n;

    dtmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .clr_n(clr_n), .sub_en(sub_en), .sel(sel_w), .tick(tick_w)
    );

    dtmr_regs #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .por_n(por_n), .clr_n(clr_n), .ram_wr_clr(ram_wr_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hw_stop(stop_w), .hw_flag_set(fset_w),
        .reload_val(reload_w), .rate_sel(sel_w), .run(run_w),
        .auto_rl(auto_w), .wdt_mode(wdt_w), .flag(flag_w),
        .start_load(load_w)
    );

    dtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .clr_n(clr_n), .load(load_w), .reload_val(reload_w),
        .tick(tick_w), .run(run_w), .auto_rl(auto_w), .wdt_mode(wdt_w),
        .count(count_w), .uf_q(underflow), .req_q(sys_rst_req),
        .hw_stop(stop_w), .hw_flag_set(fset_w)
    );

    // Assemble the control/status read value
    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CTL_WDT]  = wdt_w;
        ctrl_rd[CTL_FLAG] = flag_w;
        ctrl_rd[CTL_AUTO] = auto_w;
        ctrl_rd[CTL_RUN]  = run_w;
    end

    // Read mux by address
    always_comb begin
        case (rd_addr)
            ADDR_W'(ADR_LO):     rd_data = reload_w[NIB_W-1:0];
            ADDR_W'(ADR_HI):     rd_data = reload_w[CNT_W-1:NIB_W];
            ADDR_W'(ADR_CTRL):   rd_data = ctrl_rd;
            ADDR_W'(ADR_RATE):   rd_data = NIB_W'(sel_w);
            ADDR_W'(ADR_CNT_LO): rd_data = count_w[NIB_W-1:0];
            ADDR_W'(ADR_CNT_HI): rd_data = count_w[CNT_W-1:NIB_W];
            default:             rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dtmr_checker.sv
// Checker: temporal properties of the down-counter, bound to the top.
// Assumes the signal names of dtmr_timer's internal nets.
module dtmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             ram_wr_clr,
    input logic             underflow,
    input logic             sys_rst_req,
    input logic             run,
    input logic             auto_rl,
    input logic             flag,
    input logic [CNT_W-1:0] count
);
    p_uf_one_cycle_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        underflow |=> !underflow);

    p_req_with_uf_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        sys_rst_req |-> (underflow && flag));

    p_flag_rise_r10: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag) |-> sys_rst_req);

    p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (underflow && !auto_rl) |-> !run);

    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !run |=> (run || $stable(count)));

    p_flag_keep_r12: assert property (@(posedge clk) disable iff (!por_n)
        (flag && !ram_wr_clr) |=> flag);
endmodule

bind dtmr_timer dtmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ram_wr_clr(ram_wr_clr),
    .underflow(underflow), .sys_rst_req(sys_rst_req), .run(run_w),
    .auto_rl(auto_w), .flag(flag_w), .count(count_w)
);

// File: tb/tb_dtmr_timer.sv
module tb_dtmr_timer;
    logic       clk = 1'b0;
    logic       por_n, tb_rst_n, ram_wr_clr, sub_en, wr_en;
    logic [2:0] wr_addr, rd_addr;
    logic [3:0] wr_data, rd_data;
    logic       underflow, sys_rst_req;
    logic       rst_n;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    // The chip feeds the reset request back as system reset
    assign rst_n = tb_rst_n & ~sys_rst_req;

    dtmr_timer dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ram_wr_clr(ram_wr_clr),
        .sub_en(sub_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .underflow(underflow), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd_count(output int c);
        logic [3:0] l, h;
        rd(3'd4, l);
        rd(3'd5, h);
        c = {h, l};
    endtask

    // Advance falling edges until underflow is seen; n = edges taken
    task automatic wait_uf(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!underflow && n < limit);
    endtask

    task automatic t_reset_r1();
        logic [3:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 addr %0d", a), v, 0);
        end
        check("R1 underflow", underflow, 0);
        check("R1 sys_rst_req", sys_rst_req, 0);
    endtask

    task automatic t_regmap_r2();
        logic [3:0] v;
        int c;
        wr(3'd0, 4'hA); wr(3'd1, 4'h5); wr(3'd3, 4'hF);
        rd(3'd0, v); check("R2 low nibble", v, 4'hA);
        rd(3'd1, v); check("R2 high nibble", v, 4'h5);
        rd(3'd3, v); check("R2 rate reads 2 bits", v, 4'h3);
        wr(3'd4, 4'hF); wr(3'd6, 4'hF);
        rd_count(c); check("R2 count write ignored", c, 0);
        rd(3'd6, v); check("R2 addr 6 reads 0", v, 0);
    endtask

    task automatic t_start_r3_r4_r5();
        int c1, c2, c3, c4, n;
        wr(3'd0, 4'h5); wr(3'd1, 4'h3); wr(3'd3, 4'h3);
        wr(3'd2, 4'h8);
        rd_count(c1); check("R3 start loads reload", c1, 8'h35);
        repeat (100) @(negedge clk);
        rd_count(c1);
        check("R5 count decremented", int'(c1 < 8'h35), 1);
        wr(3'd2, 4'h8);
        rd_count(c2);
        check("R4 no reload on rewrite", int'(c2 <= c1 && c2 != 8'h35), 1);
        wr(3'd2, 4'h0);
        rd_count(c3);
        wait_uf(100, n);
        rd_count(c4);
        check("R5 stopped count holds", c4, c3);
        check("R5 no underflow while stopped", underflow, 0);
        wr(3'd2, 4'h8);
        sub_en = 1'b0;
        repeat (100) @(negedge clk);
        rd_count(c4);
        check("R5 sub_en low freezes", c4, 8'h35);
        sub_en = 1'b1;
        wr(3'd2, 4'h0);
    endtask

    task automatic t_auto_r6_r7_r9(input int code);
        int d, n, c;
        logic [3:0] v;
        d = (code == 0) ? 2 : (1 << (code + 2));
        wr(3'd0, 4'h4); wr(3'd1, 4'h0); wr(3'd3, 4'(code));
        wr(3'd2, 4'h4);
        wr(3'd2, 4'hC);
        wait_uf(2000, n);
        check($sformatf("R7 first underflow code %0d", code), underflow, 1);
        wait_uf(2000, n);
        check($sformatf("R6 interval code %0d", code), n, d * 5);
        rd_count(c); check("R7 auto reload count", c, 8'h04);
        rd(3'd2, v); check("R7 start bit kept", v, 4'hC);
        check("R9 timer mode no reset request", sys_rst_req, 0);
        @(negedge clk);
        check("R7 underflow one clock", underflow, 0);
        rd(3'd2, v); check("R9 flag unchanged", v[1], 0);
        wr(3'd2, 4'h0);
    endtask

    task automatic t_oneshot_r8();
        int n, c;
        logic [3:0] v;
        wr(3'd0, 4'h3); wr(3'd1, 4'h0); wr(3'd3, 4'h0);
        wr(3'd2, 4'h8);
        wait_uf(1000, n);
        check("R8 underflow seen", underflow, 1);
        rd(3'd2, v); check("R8 start bit cleared", v, 4'h0);
        rd_count(c); check("R8 count at FF", c, 8'hFF);
        wait_uf(300, n);
        check("R8 no further underflow", underflow, 0);
        rd_count(c); check("R8 count stays FF", c, 8'hFF);
    endtask

    task automatic fire_watchdog(input string tag);
        int n = 0;
        wr(3'd0, 4'h2); wr(3'd1, 4'h0); wr(3'd3, 4'h0);
        wr(3'd2, 4'h9);
        do begin
            @(negedge clk);
            n++;
        end while (!sys_rst_req && n < 1000);
        check({tag, " R10 reset request"}, sys_rst_req, 1);
        check({tag, " R10 underflow with request"}, underflow, 1);
        @(negedge clk);
        check({tag, " R10 request one clock"}, sys_rst_req, 0);
    endtask

    task automatic t_watchdog_r10_r11_r12();
        logic [3:0] v;
        int c;
        fire_watchdog("wdt1");
        rd(3'd2, v); check("R11 ctrl keeps only flag", v, 4'h2);
        rd(3'd0, v); check("R11 low cleared", v, 0);
        rd(3'd3, v); check("R11 rate cleared", v, 0);
        rd_count(c); check("R11 count cleared", c, 0);
        wr(3'd2, 4'h0);
        rd(3'd2, v); check("R12 write cannot clear flag", v, 4'h2);
        @(negedge clk); ram_wr_clr = 1'b1;
        @(negedge clk); ram_wr_clr = 1'b0;
        rd(3'd2, v); check("R12 ram_wr_clr clears flag", v, 4'h0);
        wr(3'd2, 4'h2);
        rd(3'd2, v); check("R12 write cannot set flag", v, 4'h0);
        fire_watchdog("wdt2");
        rd(3'd2, v); check("R10 flag set again", v, 4'h2);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd(3'd2, v); check("R12 por_n clears flag", v, 4'h0);
        t_reset_r1();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        por_n = 1'b0; tb_rst_n = 1'b1; ram_wr_clr = 1'b0; sub_en = 1'b1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset_r1();
        t_regmap_r2();
        t_start_r3_r4_r5();
        for (int code = 0; code < 4; code++) t_auto_r6_r7_r9(code);
        t_oneshot_r8();
        t_watchdog_r10_r11_r12();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule